// File: doc/BRIEF.md
# Multi-View Processor Register File

This block is the integer register file of a small 16-bit processor. It stores six 16-bit registers: four data registers (R0, R1, R2, R3) and two address registers (A0, A1). The same storage can be reached in three widths. The two lowest data registers expose their upper and lower bytes on their own. Every register can be reached as a 16-bit word. Three fixed register pairs can be reached as 32-bit values.

There are two independent read ports and one write port. Each port carries a register selector and an access-size code. Read ports also take a signed flag, which controls how narrow results are extended to the 32-bit port width. A selector and size combination that the architecture does not define is flagged on an error output. An illegal write leaves the storage unchanged. Reads are combinational from the stored state, and writes take effect at the rising clock edge.

Register indices are R0=0, R1=1, R2=2, R3=3, A0=4 and A1=5. Size codes are 0 for the low byte, 1 for the high byte, 2 for a word and 3 for a 32-bit pair. A pair is selected by the index of its lower member:
- index 0 selects R2:R0, with R2 in bits 31:16.
- index 1 selects R3:R1, with R3 in bits 31:16.
- index 4 selects A1:A0, with A1 in bits 31:16.

Top module: `multiViewRegFile`

## Requirements
- R1: A synchronous active-high reset clears all six registers, so that every word read returns zero afterwards.
- R2: A word write (size 2) with index 0 to 5 stores wrData[15:0] in that register, and a word read returns it in bits 15:0.
- R3: Byte writes are legal only for index 0 or 1. Size 0 writes wrData[7:0] into bits 7:0 and size 1 writes wrData[7:0] into bits 15:8, and the other byte of the register keeps its value.
- R4: A byte read returns the addressed byte in bits 7:0, and a word read returns the word in bits 15:0. The remaining upper bits are copies of the operand's top bit when the signed flag is 1 and are zero when it is 0.
- R5: A pair write (size 3, index 0, 1 or 4) stores wrData[15:0] in the lower member and wrData[31:16] in the upper member, both at the same clock edge.
- R6: A pair read returns the upper member in bits 31:16 and the lower member in bits 15:0, with no extension.
- R7: A write with a byte size on index 2 to 7, a word on index 6 or 7, or a pair on any index other than 0, 1 or 4 drives wrErr high in the same cycle and changes no register. A legal write or an idle port keeps wrErr low.
- R8: A read with an illegal combination (same rules as R7) drives that port's error output high and its data to zero.
- R9: A read of a register being written in the same cycle returns the old value. The new value is visible after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrSel | input | 3 | Write register index |
| wrSize | input | 2 | Write size code |
| wrData | input | 32 | Write data |
| wrErr | output | 1 | Illegal write combination |
| rdSelA | input | 3 | Read port A register index |
| rdSizeA | input | 2 | Read port A size code |
| rdSgnA | input | 1 | Read port A sign-extend |
| rdDataA | output | 32 | Read port A data |
| rdErrA | output | 1 | Read port A illegal combination |
| rdSelB | input | 3 | Read port B register index |
| rdSizeB | input | 2 | Read port B size code |
| rdSgnB | input | 1 | Read port B sign-extend |
| rdDataB | output | 32 | Read port B data |
| rdErrB | output | 1 | Read port B illegal combination |

## Verification
The hardest case to reach from the ports is a suppressed write. The bench has to show that a rejected byte or pair access touched neither the addressed register nor its would-be partner. To do this it first loads distinct word values into every register. It then issues each illegal combination and reads all six registers back as words. The same-cycle read-during-write case needs the read selector held on the register being written while the write is pending. The bench samples once before the edge and once after it.

// File: rtl/rfPkg.sv
package rfPkg;
  localparam int REG_COUNT = 6;
  localparam int REG_W     = 16;
  localparam int HALF_W    = REG_W / 2;
  localparam int PORT_W    = 2 * REG_W;
  localparam int SEL_W     = 3;
  localparam int RD_PORTS  = 2;

  typedef enum logic [1:0] {
    SZ_LO   = 2'd0,
    SZ_HI   = 2'd1,
    SZ_WORD = 2'd2,
    SZ_PAIR = 2'd3
  } accSize_t;

  typedef struct packed {
    logic [REG_COUNT-1:0] loEn;
    logic [REG_COUNT-1:0] hiEn;
    logic [REG_COUNT-1:0] useUpper;
    logic                 hiFromLow;
  } wrStrobe_t;

  // legal selector/size combinations
  function automatic logic viewOk(input logic [SEL_W-1:0] sel, input accSize_t sz);
    logic ok;
    case (sz)
      SZ_LO, SZ_HI: ok = (sel == 3'd0) || (sel == 3'd1);
      SZ_WORD:      ok = (int'(sel) < REG_COUNT);
      default:      ok = (sel == 3'd0) || (sel == 3'd1) || (sel == 3'd4);
    endcase
    return ok;
  endfunction

  // index of the upper member of a pair selected by its lower member
  function automatic logic [SEL_W-1:0] pairUpper(input logic [SEL_W-1:0] sel);
    logic [SEL_W-1:0] up;
    case (sel)
      3'd0:    up = 3'd2;
      3'd1:    up = 3'd3;
      default: up = 3'd5;
    endcase
    return up;
  endfunction
endpackage

// File: rtl/rfCtrl.sv
module rfCtrl
  import rfPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  accSize_t          wrSize,
  output wrStrobe_t         stb,
  output logic              wrErr
);
  logic             legal;
  logic [SEL_W-1:0] upIdx;

  assign legal = viewOk(wrSel, wrSize);
  assign upIdx = pairUpper(wrSel);
  assign wrErr = wrEn && !legal;

  always_comb begin
    stb = '0;
    stb.hiFromLow = (wrSize == SZ_HI);
    if (wrEn && legal) begin
      for (int i = 0; i < REG_COUNT; i++) begin
        logic isSel;
        logic isUp;
        isSel = (wrSel == i[SEL_W-1:0]);
        isUp  = (wrSize == SZ_PAIR) && (upIdx == i[SEL_W-1:0]);
        case (wrSize)
          SZ_LO:   stb.loEn[i] = isSel;
          SZ_HI:   stb.hiEn[i] = isSel;
          SZ_WORD: begin
            stb.loEn[i] = isSel;
            stb.hiEn[i] = isSel;
          end
          default: begin
            stb.loEn[i]     = isSel || isUp;
            stb.hiEn[i]     = isSel || isUp;
            stb.useUpper[i] = isUp;
          end
        endcase
      end
    end
  end

  // R7
  wr_err_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    wrErr |-> (stb.loEn == '0 && stb.hiEn == '0));

  // R5
  pair_two_regs_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSize == SZ_PAIR && !wrErr) |-> ($countones(stb.loEn) == 2 && $countones(stb.hiEn) == 2));

  // R3
  byte_single_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (wrSize == SZ_LO || wrSize == SZ_HI)) |-> ($countones(stb.loEn) + $countones(stb.hiEn) <= 1));
endmodule

// File: rtl/rfReadPort.sv
module rfReadPort
  import rfPkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic [REG_COUNT-1:0][REG_W-1:0] regs,
  input  logic [SEL_W-1:0]                sel,
  input  accSize_t                        size,
  input  logic                            sgn,
  output logic [PORT_W-1:0]               data,
  output logic                            err
);
  logic [SEL_W-1:0]  upIdx;
  logic [REG_W-1:0]  word;
  logic [REG_W-1:0]  upWord;
  logic [HALF_W-1:0] byteV;

  assign upIdx  = pairUpper(sel);
  assign word   = (int'(sel) < REG_COUNT) ? regs[sel] : '0;
  assign upWord = (int'(upIdx) < REG_COUNT) ? regs[upIdx] : '0;
  assign byteV  = (size == SZ_HI) ? word[REG_W-1:HALF_W] : word[HALF_W-1:0];

  always_comb begin
    err  = !viewOk(sel, size);
    data = '0;
    if (!err) begin
      case (size)
        SZ_LO, SZ_HI: data = {{(PORT_W-HALF_W){sgn & byteV[HALF_W-1]}}, byteV};
        SZ_WORD:      data = {{(PORT_W-REG_W){sgn & word[REG_W-1]}}, word};
        default:      data = {upWord, word};
      endcase
    end
  end

  // R8
  rd_err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (data == '0));

  // R4
  byte_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (!err && !sgn && (size == SZ_LO || size == SZ_HI)) |-> (data[PORT_W-1:HALF_W] == '0));
endmodule

// File: rtl/rfData.sv
module rfData
  import rfPkg::*;
(
  input  logic                              clk,
  input  logic                              rst,
  input  wrStrobe_t                         stb,
  input  logic [PORT_W-1:0]                 wrData,
  input  logic [RD_PORTS-1:0][SEL_W-1:0]    rdSel,
  input  accSize_t                          rdSize [RD_PORTS],
  input  logic [RD_PORTS-1:0]               rdSgn,
  output logic [RD_PORTS-1:0][PORT_W-1:0]   rdData,
  output logic [RD_PORTS-1:0]               rdErr
);
  logic [REG_COUNT-1:0][REG_W-1:0] regs;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    logic [REG_W-1:0]  srcWord;
    logic [HALF_W-1:0] hiByte;
    assign srcWord = stb.useUpper[i] ? wrData[PORT_W-1:REG_W] : wrData[REG_W-1:0];
    assign hiByte  = stb.hiFromLow ? wrData[HALF_W-1:0] : srcWord[REG_W-1:HALF_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= '0;
      end else begin
        if (stb.loEn[i]) regs[i][HALF_W-1:0]     <= srcWord[HALF_W-1:0];
        if (stb.hiEn[i]) regs[i][REG_W-1:HALF_W] <= hiByte;
      end
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(stb.loEn[i] || stb.hiEn[i]) |=> $stable(regs[i]));

    // R3
    hi_only_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
      (stb.hiEn[i] && !stb.loEn[i]) |=> (regs[i][HALF_W-1:0] == $past(regs[i][HALF_W-1:0])));
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    rfReadPort u_port (
      .clk  (clk),
      .rst  (rst),
      .regs (regs),
      .sel  (rdSel[p]),
      .size (rdSize[p]),
      .sgn  (rdSgn[p]),
      .data (rdData[p]),
      .err  (rdErr[p])
    );
  end
endmodule

// File: rtl/multiViewRegFile.sv
module multiViewRegFile
  import rfPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [2:0]  wrSel,
  input  logic [1:0]  wrSize,
  input  logic [31:0] wrData,
  output logic        wrErr,
  input  logic [2:0]  rdSelA,
  input  logic [1:0]  rdSizeA,
  input  logic        rdSgnA,
  output logic [31:0] rdDataA,
  output logic        rdErrA,
  input  logic [2:0]  rdSelB,
  input  logic [1:0]  rdSizeB,
  input  logic        rdSgnB,
  output logic [31:0] rdDataB,
  output logic        rdErrB
);
  wrStrobe_t                          stb;
  logic [RD_PORTS-1:0][SEL_W-1:0]     rdSel;
  accSize_t                           rdSize [RD_PORTS];
  logic [RD_PORTS-1:0]                rdSgn;
  logic [RD_PORTS-1:0][PORT_W-1:0]    rdData;
  logic [RD_PORTS-1:0]                rdErr;

  assign rdSel     = {rdSelB, rdSelA};
  assign rdSize[0] = accSize_t'(rdSizeA);
  assign rdSize[1] = accSize_t'(rdSizeB);
  assign rdSgn     = {rdSgnB, rdSgnA};
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];
  assign rdErrA    = rdErr[0];
  assign rdErrB    = rdErr[1];

  rfCtrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrSize (accSize_t'(wrSize)),
    .stb    (stb),
    .wrErr  (wrErr)
  );

  rfData u_data (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .wrData (wrData),
    .rdSel  (rdSel),
    .rdSize (rdSize),
    .rdSgn  (rdSgn),
    .rdData (rdData),
    .rdErr  (rdErr)
  );
endmodule

// File: tb/sim_multiViewRegFile.sv
module sim_multiViewRegFile;
  logic        clk = 0;
  logic        rst = 1;
  logic        wrEn = 0;
  logic [2:0]  wrSel = 0;
  logic [1:0]  wrSize = 0;
  logic [31:0] wrData = 0;
  logic        wrErr;
  logic [2:0]  rdSelA = 0, rdSelB = 0;
  logic [1:0]  rdSizeA = 2, rdSizeB = 2;
  logic        rdSgnA = 0, rdSgnB = 0;
  logic [31:0] rdDataA, rdDataB;
  logic        rdErrA, rdErrB;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  multiViewRegFile u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] sel, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrSel = sel; wrSize = sz; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic readA(input logic [2:0] sel, input logic [1:0] sz, input logic sg,
                       output logic [31:0] d, output logic e);
    rdSelA = sel; rdSizeA = sz; rdSgnA = sg;
    #1;
    d = rdDataA; e = rdErrA;
  endtask

  task automatic readB(input logic [2:0] sel, input logic [1:0] sz, input logic sg,
                       output logic [31:0] d, output logic e);
    rdSelB = sel; rdSizeB = sz; rdSgnB = sg;
    #1;
    d = rdDataB; e = rdErrB;
  endtask

  task automatic testReset();
    logic [31:0] d; logic e;
    for (int i = 0; i < 6; i++) begin
      readA(i[2:0], 2, 0, d, e);
      check("R1 reset word A", d, 0);
      readB(i[2:0], 2, 1, d, e);
      check("R1 reset word B", d, 0);
    end
  endtask

  task automatic testWord();
    logic [31:0] d; logic e;
    for (int i = 0; i < 6; i++) doWrite(i[2:0], 2, 32'hFFFF_0000 | (32'h1011 * (i + 1)));
    for (int i = 0; i < 6; i++) begin
      readA(i[2:0], 2, 0, d, e);
      check("R2 word read A", d, 32'h1011 * (i + 1));
      readB(i[2:0], 2, 0, d, e);
      check("R2 word read B", d, 32'h1011 * (i + 1));
      check("R2 no err", {31'd0, e}, 0);
    end
  endtask

  task automatic testByte();
    logic [31:0] d; logic e;
    doWrite(0, 2, 32'h1234);
    doWrite(0, 0, 32'hFFFF_FFAB);
    readA(0, 2, 0, d, e); check("R3 R0 low byte write", d, 32'h12AB);
    doWrite(0, 1, 32'h0000_00CD);
    readA(0, 2, 0, d, e); check("R3 R0 high byte write", d, 32'hCDAB);
    doWrite(1, 2, 32'h5678);
    doWrite(1, 1, 32'h0000_9A3C);
    readA(1, 2, 0, d, e); check("R3 R1 high byte write", d, 32'h3C78);
    doWrite(1, 0, 32'h0000_0011);
    readA(1, 2, 0, d, e); check("R3 R1 low byte write", d, 32'h3C11);
    readB(0, 2, 0, d, e); check("R3 R0 untouched by R1", d, 32'hCDAB);
  endtask

  task automatic testExtend();
    logic [31:0] d; logic e;
    doWrite(0, 2, 32'h80F0);
    doWrite(1, 2, 32'h7F01);
    readA(0, 0, 0, d, e); check("R4 lo unsigned", d, 32'h0000_00F0);
    readA(0, 0, 1, d, e); check("R4 lo signed", d, 32'hFFFF_FFF0);
    readB(0, 1, 1, d, e); check("R4 hi signed", d, 32'hFFFF_FF80);
    readB(0, 1, 0, d, e); check("R4 hi unsigned", d, 32'h0000_0080);
    readA(1, 1, 1, d, e); check("R4 hi signed positive", d, 32'h0000_007F);
    readA(0, 2, 1, d, e); check("R4 word signed", d, 32'hFFFF_80F0);
    readB(0, 2, 0, d, e); check("R4 word unsigned", d, 32'h0000_80F0);
  endtask

  task automatic testPairWrite();
    logic [31:0] d; logic e;
    doWrite(0, 3, 32'hAAAA_5555);
    readA(2, 2, 0, d, e); check("R5 R2 upper of pair", d, 32'hAAAA);
    readB(0, 2, 0, d, e); check("R5 R0 lower of pair", d, 32'h5555);
    doWrite(1, 3, 32'h1234_ABCD);
    readA(3, 2, 0, d, e); check("R5 R3 upper of pair", d, 32'h1234);
    readB(1, 2, 0, d, e); check("R5 R1 lower of pair", d, 32'hABCD);
    doWrite(4, 3, 32'hDEAD_BEEF);
    readA(5, 2, 0, d, e); check("R5 A1 upper of pair", d, 32'hDEAD);
    readB(4, 2, 0, d, e); check("R5 A0 lower of pair", d, 32'hBEEF);
    readA(2, 2, 0, d, e); check("R5 R2 untouched by A pair", d, 32'hAAAA);
  endtask

  task automatic testPairRead();
    logic [31:0] d; logic e;
    doWrite(2, 2, 32'h0102);
    doWrite(0, 2, 32'h0304);
    doWrite(3, 2, 32'h8899);
    doWrite(1, 2, 32'hF00D);
    readA(0, 3, 1, d, e); check("R6 R2R0 read", d, 32'h0102_0304);
    readB(1, 3, 1, d, e); check("R6 R3R1 read", d, 32'h8899_F00D);
    readA(4, 3, 0, d, e); check("R6 A1A0 read", d, 32'hDEAD_BEEF);
  endtask

  task automatic testIllegalWrite();
    logic [31:0] d; logic e;
    logic [2:0] badSel [5] = '{3'd2, 3'd4, 3'd6, 3'd2, 3'd5};
    logic [1:0] badSz  [5] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3};
    for (int i = 0; i < 6; i++) doWrite(i[2:0], 2, 32'h0A00 + i);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      wrEn = 1; wrSel = badSel[k]; wrSize = badSz[k]; wrData = 32'hFFFF_FFFF;
      #1; check("R7 wrErr high", {31'd0, wrErr}, 1);
      @(negedge clk);
      wrEn = 0;
      for (int i = 0; i < 6; i++) begin
        readA(i[2:0], 2, 0, d, e);
        check("R7 register unchanged", d, 32'h0A00 + i);
      end
    end
    @(negedge clk);
    wrEn = 1; wrSel = 3; wrSize = 2; wrData = 32'h0BBB;
    #1; check("R7 legal write no err", {31'd0, wrErr}, 0);
    @(negedge clk);
    wrEn = 0;
    #1; check("R7 idle no err", {31'd0, wrErr}, 0);
  endtask

  task automatic testIllegalRead();
    logic [31:0] d; logic e;
    readA(3, 0, 0, d, e);
    check("R8 byte R3 err", {31'd0, e}, 1); check("R8 byte R3 data", d, 0);
    readB(5, 1, 1, d, e);
    check("R8 byte A1 err", {31'd0, e}, 1); check("R8 byte A1 data", d, 0);
    readA(7, 2, 0, d, e);
    check("R8 word idx7 err", {31'd0, e}, 1); check("R8 word idx7 data", d, 0);
    readB(3, 3, 0, d, e);
    check("R8 pair idx3 err", {31'd0, e}, 1); check("R8 pair idx3 data", d, 0);
  endtask

  task automatic testSameCycle();
    logic [31:0] d; logic e;
    doWrite(3, 2, 32'h1111);
    doWrite(4, 3, 32'h3333_4444);
    @(negedge clk);
    wrEn = 1; wrSel = 3; wrSize = 2; wrData = 32'h2222;
    readA(3, 2, 0, d, e); check("R9 old value before edge", d, 32'h1111);
    @(posedge clk); #1;
    wrEn = 0;
    readA(3, 2, 0, d, e); check("R9 new value after edge", d, 32'h2222);
    @(negedge clk);
    wrEn = 1; wrSel = 4; wrSize = 3; wrData = 32'h5555_6666;
    readB(4, 3, 0, d, e); check("R9 old pair before edge", d, 32'h3333_4444);
    @(posedge clk); #1;
    wrEn = 0;
    readB(4, 3, 0, d, e); check("R9 new pair after edge", d, 32'h5555_6666);
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // put nonzero data on the write bus during reset to show reset wins
    wrData = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst = 0;
    wrData = 0;
    testReset();
    testWord();
    testByte();
    testExtend();
    testPairWrite();
    testPairRead();
    testIllegalWrite();
    testIllegalRead();
    testSameCycle();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    testReset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule